// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block turns the virtual address of an instruction fetch into a physical address. It holds a small set-associative table of page entries. Each entry is two words. The tag word holds the virtual page number, a valid flag and a small age counter. The mapping word holds the physical page number, a cache-inhibit flag and two execute-permission flags, one for supervisor code and one for user code. The owning core loads entries through a register-style write port and can read them back through a read port. The block has no refill of its own: a lookup that misses raises a miss pulse, and the core resolves it.

Each accepted fetch request gives a registered result after a fixed latency. There is one latency for hits and one for misses. The result is marked by a one-cycle `done_o` strobe. An execute-permission failure on a hit raises a page-fault pulse. When translation is switched off, the address passes straight through, and the cache-inhibit flag comes from the top address bit. A separate combinational probe port performs the same lookup without changing any state. A constant configuration output reports the geometry of the table.

Top module: `itlb_xlate`

## Requirements
- R1: When `xl_en_i` is low, a fetch result carries `pa_o` equal to the virtual address, `ci_o` equal to address bit 31 (set for addresses at or above 0x80000000), and `hit_o`, `miss_o` and `fault_o` all low.
- R2: The set is (va >> PAGE_LOG2) & (NSETS-1). The tag compare covers the address bits at and above PAGE_LOG2 + log2(NSETS), so addresses that differ only below that boundary share a tag.
- R3: A way hits only when bit 0 (valid) of its tag word is set and its tag bits equal those of the address. When several ways hit, the lowest-numbered way is used.
- R4: On a hit, `pa_o` = (mapping word with bits below PAGE_LOG2 cleared) OR (va & (2^PAGE_LOG2 - 1)), and `ci_o` = bit 1 of the mapping word.
- R5: On an enabled hit, every other way of the set whose 2-bit age field (tag-word bits 7:6) is non-zero loses one. The age field of the hit way is loaded with (NSETS-1) truncated to 2 bits.
- R6: On a miss, no entry changes. `miss_o` pulses with `exc_va_o` equal to the virtual address, `pa_o` is zero, and `ci_o` is low.
- R7: On a hit, the required permission is mapping-word bit 6 when `sup_i` is high and bit 7 when it is low. If that bit is clear, `fault_o` pulses with `exc_va_o` equal to the virtual address. The translated address is still reported.
- R8: The probe port changes no age field and raises no pulse. `probe_pa_o` is the translated address on a permitted hit, zero on a miss or a permission failure, and the probe address unchanged when translation is off.
- R9: The result appears with `done_o` HIT_LAT cycles after the accepting clock edge for hits and pass-through, and MISS_LAT cycles after it for misses. `done_o` is high for exactly one cycle. A request is accepted when the block is idle or in the cycle its previous result is shown.
- R10: `wr_sel_i` 0 writes the tag word and 1 writes the mapping word of (`wr_way_i`, `wr_set_i`). The read port returns the selected word in the same cycle. A fetch accepted in the same cycle as a tag write looks up the old contents, and the written value is what remains afterwards, including over an age update.
- R11: `cfg_o` bits 1:0 hold NWAYS-1 and bits 4:2 hold log2(NSETS). The other bits are zero.
- R12: After reset, every word of the table is zero (all entries invalid) and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_en_i | input | 1 | Translation enable |
| sup_i | input | 1 | Supervisor mode of the fetch |
| req_i | input | 1 | Fetch lookup request |
| va_i | input | ADDR_W | Fetch virtual address |
| done_o | output | 1 | Result strobe |
| hit_o | output | 1 | Result was a table hit |
| miss_o | output | 1 | Miss exception pulse |
| fault_o | output | 1 | Execute-permission fault pulse |
| pa_o | output | ADDR_W | Physical address |
| ci_o | output | 1 | Cache-inhibit flag |
| exc_va_o | output | ADDR_W | Virtual address of the result |
| wr_en_i | input | 1 | Entry write strobe |
| wr_sel_i | input | 1 | 0 = tag word, 1 = mapping word |
| wr_way_i | input | WAY_W | Way to write |
| wr_set_i | input | SET_W | Set to write |
| wr_data_i | input | ADDR_W | Write data |
| rd_sel_i | input | 1 | Read word select |
| rd_way_i | input | WAY_W | Way to read |
| rd_set_i | input | SET_W | Set to read |
| rd_data_o | output | ADDR_W | Read data |
| probe_va_i | input | ADDR_W | Probe virtual address |
| probe_pa_o | output | ADDR_W | Probe result |
| cfg_o | output | 8 | Geometry report |

## Verification
A fetch lookup and an entry write can land on the same clock edge, and in the worst case they target the very tag word whose age field the lookup is reloading. The bench issues a fetch that hits way 0 while it rewrites that tag word with a different tag. The fetch result must still be the hit computed from the old tag. The read port must then show exactly the written word, with no reloaded age bits merged in. Probes issued between fetches check that a lookup with no side effects leaves every age field unchanged.

// File: rtl/itlb_pkg.sv
// Package: shared field positions and the word-select encoding of the
// instruction translator. Assumes addresses of at least 8 bits.
package itlb_pkg;
    localparam int TAG_VALID_BIT = 0;   // valid flag in the tag word
    localparam int AGE_LSB       = 6;   // age field low bit in the tag word
    localparam int AGE_W         = 2;   // age field width
    localparam int MAP_CI_BIT    = 1;   // cache-inhibit in the mapping word
    localparam int MAP_SX_BIT    = 6;   // supervisor execute permission
    localparam int MAP_UX_BIT    = 7;   // user execute permission

    typedef enum logic {
        SEL_TAG = 1'b0,
        SEL_MAP = 1'b1
    } word_sel_e;
endpackage

// File: rtl/itlb_lookup.sv
// Module: itlb_lookup
// Compares one address against all ways of a selected set and forms the
// translated address, cache-inhibit and permission result. Purely
// combinational. Assumes the caller has already picked the set rows.
module itlb_lookup
    import itlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NWAYS     = 2,
    parameter int NSETS     = 4,
    parameter int PAGE_LOG2 = 13,
    localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic [NWAYS-1:0][ADDR_W-1:0] tag_row_i,
    input  logic [NWAYS-1:0][ADDR_W-1:0] map_row_i,
    input  logic [ADDR_W-1:0]            va_i,
    input  logic                         sup_i,
    output logic                         hit_o,
    output logic [WAY_W-1:0]             way_o,
    output logic [ADDR_W-1:0]            pa_o,
    output logic                         ci_o,
    output logic                         perm_o
);
    localparam int TAG_LSB = PAGE_LOG2 + $clog2(NSETS);
    localparam logic [ADDR_W-1:0] TAG_MASK  = {ADDR_W{1'b1}} << TAG_LSB;
    localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_LOG2;

    logic [NWAYS-1:0]  way_hit;
    logic [ADDR_W-1:0] map_sel;

    // Per-way tag comparison, one comparator per way.
    for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
        assign way_hit[w] = tag_row_i[w][TAG_VALID_BIT] &&
                            ((tag_row_i[w] & TAG_MASK) == (va_i & TAG_MASK));
    end

    // Priority pick: lowest-numbered hitting way wins.
    always_comb begin
        way_o = '0;
        for (int w = NWAYS - 1; w >= 0; w--) begin
            if (way_hit[w]) way_o = WAY_W'(w);
        end
    end

    assign hit_o   = |way_hit;
    assign map_sel = map_row_i[way_o];
    assign pa_o    = (map_sel & PAGE_MASK) | (va_i & ~PAGE_MASK);
    assign ci_o    = map_sel[MAP_CI_BIT];
    assign perm_o  = sup_i ? map_sel[MAP_SX_BIT] : map_sel[MAP_UX_BIT];
endmodule

// File: rtl/itlb_resp.sv
// Module: itlb_resp
// Captures a lookup outcome on acceptance and presents it after the hit or
// miss latency with a one-cycle done strobe. Assumes HIT_LAT, MISS_LAT >= 1.
module itlb_resp #(
    parameter int ADDR_W   = 32,
    parameter int HIT_LAT  = 1,
    parameter int MISS_LAT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              byp_i,
    input  logic              hit_i,
    input  logic              perm_i,
    input  logic [ADDR_W-1:0] pa_i,
    input  logic              ci_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              hit_o,
    output logic              miss_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] pa_o,
    output logic              ci_o,
    output logic [ADDR_W-1:0] exc_va_o
);
    localparam int MAXL  = (HIT_LAT > MISS_LAT) ? HIT_LAT : MISS_LAT;
    localparam int CNT_W = $clog2(MAXL + 1);

    logic             pend_q, hit_q, miss_q, flt_q, ci_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ADDR_W-1:0] pa_q, va_q;
    logic             is_miss;

    assign is_miss = !byp_i && !hit_i;

    // Result capture and latency countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            hit_q  <= 1'b0;
            miss_q <= 1'b0;
            flt_q  <= 1'b0;
            ci_q   <= 1'b0;
            cnt_q  <= '0;
            pa_q   <= '0;
            va_q   <= '0;
        end else if (acc_i) begin
            pend_q <= 1'b1;
            hit_q  <= !byp_i && hit_i;
            miss_q <= is_miss;
            flt_q  <= !byp_i && hit_i && !perm_i;
            pa_q   <= byp_i ? va_i : (hit_i ? pa_i : '0);
            ci_q   <= byp_i ? va_i[ADDR_W-1] : (hit_i && ci_i);
            va_q   <= va_i;
            cnt_q  <= is_miss ? CNT_W'(MISS_LAT - 1) : CNT_W'(HIT_LAT - 1);
        end else if (pend_q) begin
            if (cnt_q == '0) pend_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy_o   = pend_q;
    assign done_o   = pend_q && (cnt_q == '0);
    assign hit_o    = done_o && hit_q;
    assign miss_o   = done_o && miss_q;
    assign fault_o  = done_o && flt_q;
    assign pa_o     = pa_q;
    assign ci_o     = ci_q;
    assign exc_va_o = va_q;

    // R6: a miss result never carries an address or a hit.
    a_r6_miss_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
        miss_o |-> (pa_o == '0) && !hit_o && !ci_o);
    // R7: a permission fault only accompanies a hit.
    a_r7_fault_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> hit_o);
    // R9: done is a single-cycle strobe unless a new request was accepted.
    a_r9_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !acc_i) |=> !done_o);
endmodule

// File: rtl/itlb_xlate.sv
// Module: itlb_xlate (top)
// Set-associative instruction translator: entry storage, age update, fetch
// and probe lookups, registered result. Assumes NSETS is a power of two
// <= 128 and NWAYS is 1..4. Only one fetch result is in flight at a time.
module itlb_xlate
    import itlb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NWAYS     = 2,
    parameter int NSETS     = 4,
    parameter int PAGE_LOG2 = 13,
    parameter int HIT_LAT   = 1,
    parameter int MISS_LAT  = 1,
    parameter bit PRESENT   = 1'b1,
    localparam int WAY_W    = (NWAYS > 1) ? $clog2(NWAYS) : 1,
    localparam int SET_W    = (NSETS > 1) ? $clog2(NSETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xl_en_i,
    input  logic              sup_i,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic              done_o,
    output logic              hit_o,
    output logic              miss_o,
    output logic              fault_o,
    output logic [ADDR_W-1:0] pa_o,
    output logic              ci_o,
    output logic [ADDR_W-1:0] exc_va_o,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [WAY_W-1:0]  wr_way_i,
    input  logic [SET_W-1:0]  wr_set_i,
    input  logic [ADDR_W-1:0] wr_data_i,
    input  logic              rd_sel_i,
    input  logic [WAY_W-1:0]  rd_way_i,
    input  logic [SET_W-1:0]  rd_set_i,
    output logic [ADDR_W-1:0] rd_data_o,
    input  logic [ADDR_W-1:0] probe_va_i,
    output logic [ADDR_W-1:0] probe_pa_o,
    output logic [7:0]        cfg_o
);
    localparam logic [AGE_W-1:0] AGE_RELOAD = AGE_W'(NSETS - 1);
    localparam logic [SET_W-1:0] SET_MASK   = SET_W'(NSETS - 1);

    logic [ADDR_W-1:0] tag_q [NWAYS][NSETS];
    logic [ADDR_W-1:0] map_q [NWAYS][NSETS];

    logic                         bypass, busy, accept, age_upd;
    logic [SET_W-1:0]             f_set, p_set;
    logic [NWAYS-1:0][ADDR_W-1:0] f_tag, f_map, p_tag, p_map;
    logic                         f_hit, f_ci, f_perm, p_hit, p_ci, p_perm;
    logic [WAY_W-1:0]             f_way, p_way;
    logic [ADDR_W-1:0]            f_pa, p_pa;

    assign bypass  = !xl_en_i || !PRESENT;
    assign f_set   = SET_W'(va_i >> PAGE_LOG2) & SET_MASK;
    assign p_set   = SET_W'(probe_va_i >> PAGE_LOG2) & SET_MASK;
    assign accept  = req_i && (!busy || done_o);
    assign age_upd = accept && !bypass && f_hit;

    // Row selection for the fetch and probe lookups.
    always_comb begin
        for (int w = 0; w < NWAYS; w++) begin
            f_tag[w] = tag_q[w][f_set];
            f_map[w] = map_q[w][f_set];
            p_tag[w] = tag_q[w][p_set];
            p_map[w] = map_q[w][p_set];
        end
    end

    itlb_lookup #(.ADDR_W(ADDR_W), .NWAYS(NWAYS), .NSETS(NSETS),
                  .PAGE_LOG2(PAGE_LOG2)) u_fetch_lk (
        .tag_row_i(f_tag), .map_row_i(f_map), .va_i(va_i), .sup_i(sup_i),
        .hit_o(f_hit), .way_o(f_way), .pa_o(f_pa), .ci_o(f_ci),
        .perm_o(f_perm));

    itlb_lookup #(.ADDR_W(ADDR_W), .NWAYS(NWAYS), .NSETS(NSETS),
                  .PAGE_LOG2(PAGE_LOG2)) u_probe_lk (
        .tag_row_i(p_tag), .map_row_i(p_map), .va_i(probe_va_i),
        .sup_i(sup_i), .hit_o(p_hit), .way_o(p_way), .pa_o(p_pa),
        .ci_o(p_ci), .perm_o(p_perm));

    // Entry storage: age update on a hit, then the port write (write wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWAYS; w++) begin
                for (int s = 0; s < NSETS; s++) begin
                    tag_q[w][s] <= '0;
                    map_q[w][s] <= '0;
                end
            end
        end else begin
            if (age_upd) begin
                for (int w = 0; w < NWAYS; w++) begin
                    if (WAY_W'(w) == f_way)
                        tag_q[w][f_set][AGE_LSB +: AGE_W] <= AGE_RELOAD;
                    else if (tag_q[w][f_set][AGE_LSB +: AGE_W] != '0)
                        tag_q[w][f_set][AGE_LSB +: AGE_W] <=
                            tag_q[w][f_set][AGE_LSB +: AGE_W] - 1'b1;
                end
            end
            if (wr_en_i && (int'(wr_way_i) < NWAYS)) begin
                if (wr_sel_i == SEL_TAG) tag_q[wr_way_i][wr_set_i] <= wr_data_i;
                else                     map_q[wr_way_i][wr_set_i] <= wr_data_i;
            end
        end
    end

    itlb_resp #(.ADDR_W(ADDR_W), .HIT_LAT(HIT_LAT), .MISS_LAT(MISS_LAT)) u_resp (
        .clk(clk), .rst_n(rst_n), .acc_i(accept), .byp_i(bypass),
        .hit_i(f_hit), .perm_i(f_perm), .pa_i(f_pa), .ci_i(f_ci),
        .va_i(va_i), .busy_o(busy), .done_o(done_o), .hit_o(hit_o),
        .miss_o(miss_o), .fault_o(fault_o), .pa_o(pa_o), .ci_o(ci_o),
        .exc_va_o(exc_va_o));

    // Read port and side-effect-free probe result.
    assign rd_data_o  = (int'(rd_way_i) >= NWAYS) ? '0 :
                        (rd_sel_i == SEL_TAG) ? tag_q[rd_way_i][rd_set_i]
                                              : map_q[rd_way_i][rd_set_i];
    assign probe_pa_o = bypass ? probe_va_i : ((p_hit && p_perm) ? p_pa : '0);
    assign cfg_o      = {3'b000, 3'($clog2(NSETS)), 2'(NWAYS - 1)};

    // R5: the hit way's age field holds the reload value after the update.
    a_r5_age_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (age_upd && !wr_en_i) |=>
        (tag_q[$past(f_way)][$past(f_set)][AGE_LSB +: AGE_W] == AGE_RELOAD));
    // R8: a non-zero probe result with translation on requires a probe hit.
    a_r8_probe_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && (probe_pa_o != '0)) |-> (p_hit && p_perm));
    // R10: a tag write with no lookup lands exactly as written.
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_sel_i == SEL_TAG) && !age_upd) |=>
        (tag_q[$past(wr_way_i)][$past(wr_set_i)] == $past(wr_data_i)));
endmodule

// File: tb/itlb_xlate_tb.sv
// Bench: directed corner cases plus seeded random fetches, writes and probes,
// checked against a bench-side model of the table.
module itlb_xlate_tb_top;
    localparam int NW = 2, NS = 4, PL = 13, HL = 1, ML = 2;
    localparam logic [31:0] TMASK = 32'hFFFF_FFFF << (PL + 2);
    localparam logic [31:0] PMASK = 32'hFFFF_FFFF << PL;

    logic clk = 1'b0, rst_n = 1'b0;
    logic xl_en = 1'b0, sup = 1'b0, req = 1'b0;
    logic [31:0] va = '0;
    logic done, hit, miss, fault, ci;
    logic [31:0] pa, exc_va, rd_data, probe_pa, probe_va = '0, wr_data = '0;
    logic wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic wr_way = 1'b0, rd_way = 1'b0;
    logic [1:0] wr_set = '0, rd_set = '0;
    logic [7:0] cfg;

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [31:0] m_tag [NW][NS];
    logic [31:0] m_map [NW][NS];
    logic [31:0] pool [8];

    always #4 clk = ~clk;

    itlb_xlate #(.NWAYS(NW), .NSETS(NS), .PAGE_LOG2(PL), .HIT_LAT(HL),
                 .MISS_LAT(ML)) dut_i (
        .clk(clk), .rst_n(rst_n), .xl_en_i(xl_en), .sup_i(sup), .req_i(req),
        .va_i(va), .done_o(done), .hit_o(hit), .miss_o(miss),
        .fault_o(fault), .pa_o(pa), .ci_o(ci), .exc_va_o(exc_va),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_way_i(wr_way),
        .wr_set_i(wr_set), .wr_data_i(wr_data), .rd_sel_i(rd_sel),
        .rd_way_i(rd_way), .rd_set_i(rd_set), .rd_data_o(rd_data),
        .probe_va_i(probe_va), .probe_pa_o(probe_pa), .cfg_o(cfg));

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic int set_of(input logic [31:0] a);
        return int'((a >> PL) & 32'(NS - 1));
    endfunction

    // Model lookup: returns hitting way (lowest) or -1.
    function automatic int find_way(input logic [31:0] a);
        int s = set_of(a);
        for (int w = 0; w < NW; w++)
            if (m_tag[w][s][0] && ((m_tag[w][s] & TMASK) == (a & TMASK))) return w;
        return -1;
    endfunction

    function automatic bit perm_of(input logic [31:0] mw, input bit s);
        return s ? mw[6] : mw[7];
    endfunction

    task automatic wr(input bit sel, input int w, input int s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_way = w[0]; wr_set = s[1:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (sel) m_map[w][s] = d; else m_tag[w][s] = d;
    endtask

    task automatic check_set(input int s, input string rq);
        rd_sel = 1'b0; rd_set = s[1:0];
        for (int w = 0; w < NW; w++) begin
            rd_way = w[0];
            #1;
            chk(rq, rd_data, m_tag[w][s]);
        end
    endtask

    // Fetch with optional concurrent tag write to way cw_way of the same set.
    task automatic fetch(input logic [31:0] a, input bit s, input bit en,
                         input bit cw, input int cw_way, input logic [31:0] cwd);
        int st = set_of(a);
        int w = en ? find_way(a) : -1;
        bit e_hit = (w >= 0);
        bit e_miss = en && !e_hit;
        bit e_flt = e_hit && !perm_of(m_map[w < 0 ? 0 : w][st], s);
        logic [31:0] e_pa;
        bit e_ci;
        int e_lat = e_miss ? ML : HL;
        int lat;
        if (!en) begin e_pa = a; e_ci = a[31]; end
        else if (e_hit) begin
            e_pa = (m_map[w][st] & PMASK) | (a & ~PMASK);
            e_ci = m_map[w][st][1];
        end else begin e_pa = '0; e_ci = 1'b0; end
        if (e_hit) begin
            for (int k = 0; k < NW; k++) begin
                if (k == w) m_tag[k][st][7:6] = 2'(NS - 1);
                else if (m_tag[k][st][7:6] != 0) m_tag[k][st][7:6] = m_tag[k][st][7:6] - 1;
            end
        end
        if (cw) m_tag[cw_way][st] = cwd;
        @(negedge clk);
        req = 1'b1; va = a; sup = s; xl_en = en;
        if (cw) begin
            wr_en = 1'b1; wr_sel = 1'b0; wr_way = cw_way[0]; wr_set = st[1:0]; wr_data = cwd;
        end
        @(negedge clk);
        req = 1'b0; wr_en = 1'b0;
        lat = 1;
        while (!done && lat < 10) begin @(negedge clk); lat++; end
        chk("R9 latency", 32'(lat), 32'(e_lat));
        chk(en ? "R3 hit" : "R1 hit", {31'b0, hit}, {31'b0, e_hit});
        chk("R6 miss", {31'b0, miss}, {31'b0, e_miss});
        chk("R7 fault", {31'b0, fault}, {31'b0, e_flt});
        chk(!en ? "R1 pa" : (e_hit ? "R4 pa" : "R6 pa"), pa, e_pa);
        chk(!en ? "R1 ci" : "R4 ci", {31'b0, ci}, {31'b0, e_ci});
        if (e_miss || e_flt) chk("R6 R7 exc va", exc_va, a);
        @(negedge clk);
        chk("R9 single done", {31'b0, done}, 32'b0);
        check_set(st, cw ? "R10 concurrent" : (e_hit ? "R5 age" : "R6 unchanged"));
    endtask

    task automatic probe(input logic [31:0] a, input bit s, input bit en);
        int st = set_of(a);
        int w = find_way(a);
        logic [31:0] e;
        if (!en) e = a;
        else if (w >= 0 && perm_of(m_map[w][st], s))
            e = (m_map[w][st] & PMASK) | (a & ~PMASK);
        else e = '0;
        @(negedge clk);
        probe_va = a; sup = s; xl_en = en;
        #1;
        chk("R8 probe", probe_pa, e);
        @(negedge clk);
        chk("R8 no pulse", {31'b0, done}, 32'b0);
        check_set(st, "R8 ages kept");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int w = 0; w < NW; w++)
            for (int s = 0; s < NS; s++) begin m_tag[w][s] = '0; m_map[w][s] = '0; end
        for (int k = 0; k < 8; k++) pool[k] = $urandom() & TMASK;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state.
        chk("R12 done", {31'b0, done}, 32'b0);
        check_set(0, "R12 empty");
        check_set(3, "R12 empty");
        // R11: geometry report.
        chk("R11 cfg", {24'b0, cfg}, 32'h9);
        // R1: pass-through both halves of the address space.
        fetch(32'h8000_1234, 1'b0, 1'b0, 1'b0, 0, '0);
        fetch(32'h7FFF_FFFC, 1'b1, 1'b0, 1'b0, 0, '0);
        // R6: miss on empty table.
        fetch(32'h0000_4000, 1'b1, 1'b1, 1'b0, 0, '0);
        // R3: both ways hold the same tag; way 0 wins.
        wr(1'b0, 0, 2, 32'h0012_8000 | 32'h41);
        wr(1'b1, 0, 2, 32'hABCD_E000 | 32'hC2);
        wr(1'b0, 1, 2, 32'h0012_8000 | 32'h81);
        wr(1'b1, 1, 2, 32'h5555_4000 | 32'hC0);
        // R2: same tag, offsets differing inside the page; R5 ages.
        fetch(32'h0012_C123, 1'b1, 1'b1, 1'b0, 0, '0);
        fetch(32'h0012_DFFF, 1'b0, 1'b1, 1'b0, 0, '0);
        // R3: invalid entry misses.
        wr(1'b0, 0, 1, 32'h0040_0000);
        fetch(32'h0040_2000, 1'b1, 1'b1, 1'b0, 0, '0);
        // R7: permission only for supervisor.
        wr(1'b0, 0, 1, 32'h0040_0001);
        wr(1'b1, 0, 1, 32'h1111_0040);
        fetch(32'h0040_2010, 1'b1, 1'b1, 1'b0, 0, '0);
        fetch(32'h0040_2010, 1'b0, 1'b1, 1'b0, 0, '0);
        // R8: probes.
        probe(32'h0040_2010, 1'b1, 1'b1);
        probe(32'h0040_2010, 1'b0, 1'b1);
        probe(32'h0012_C000, 1'b1, 1'b1);
        probe(32'hDEAD_BEEF, 1'b1, 1'b0);
        // R10: concurrent tag write to the hitting way.
        fetch(32'h0012_C004, 1'b1, 1'b1, 1'b1, 0, 32'h0077_8001);
        fetch(32'h0012_C004, 1'b1, 1'b1, 1'b0, 0, '0);
        // Random mix.
        for (int i = 0; i < 300; i++) begin
            int op = int'($urandom_range(0, 9));
            int k = int'($urandom_range(0, 7));
            int s = int'($urandom_range(0, NS - 1));
            logic [31:0] a = pool[k] | (32'(s) << PL) | ($urandom() & 32'h1FFF);
            if (op < 3) begin
                int w = int'($urandom_range(0, NW - 1));
                if ($urandom_range(0, 1) == 0)
                    wr(1'b0, w, s, pool[k] | ($urandom() & 32'hC0) |
                       32'($urandom_range(0, 9) != 0));
                else
                    wr(1'b1, w, s, $urandom());
            end else if (op < 9) begin
                fetch(a, 1'($urandom()), $urandom_range(0, 9) != 0, 1'b0, 0, '0);
            end else begin
                probe(a, 1'($urandom()), $urandom_range(0, 9) != 0);
            end
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule